// File: doc/BRIEF.md
# Early-Terminating Block-Matching Motion Estimator

This block runs an integer full search for one square block of current-frame pixels inside a reference window. The window extends the block by a fixed range on every side. For each candidate displacement it accumulates the sum of absolute pixel differences (SAD). At the end it reports the displacement with the lowest cost and the cost itself. The caller loads the block and the window onto the input buses, supplies a predicted vector, pulses `start`, and reads the result once `done` rises.

The cost of each candidate is built in two steps. A wide combinational stage sums the even rows of the block in a single cycle. A narrow stage then adds the odd rows, one per cycle. It does this only while the running total stays below the best complete cost found so far. A candidate is dropped at the hand-off if its even-row total already reaches that best cost. It is also dropped as soon as its running total reaches it during the row-by-row pass. The two stages overlap: the wide stage prepares the next candidate while the narrow stage works. The predicted vector is evaluated first, so that the bound is tight from the start and most later candidates are dropped early.

Top module: `sad_motion_est`

## Requirements
- R1: After an accepted `start`, `best_sad` equals the minimum SAD over all (2*RANGE+1)^2 displacements when `done` is high. Pixel layout: `cur_blk` pixel (r,c) is at bits [(r*BLK+c)*PIX_W +: PIX_W]. `win_pix` pixel (y,x) is at bits [(y*WIN+x)*PIX_W +: PIX_W], with WIN = BLK+2*RANGE. Displacement (dx,dy) compares cur(r,c) with win(r+dy+RANGE, c+dx+RANGE).
- R2: When several displacements share the minimum, the one reported is the earliest in search order. The clamped predicted vector comes first. The rest follow in raster order: dy from -RANGE to +RANGE in the outer loop, dx from -RANGE to +RANGE in the inner loop. Only a strictly lower cost replaces the current best.
- R3: Each component of the predicted vector is clamped to [-RANGE, +RANGE] before it is evaluated.
- R4: Once `done` is high it stays high, and `best_mv_x`, `best_mv_y` and `best_sad` stay constant until the next accepted `start`. A `start` seen while `busy` is high is ignored.
- R5: After reset, `busy` = 0, `done` = 0, `best_sad` is all ones and the best vector is (0,0).
- R6: If the predicted displacement has SAD 0, `done` rises no later than NCAND+BLK/2+2 clock edges after the edge that accepts `start`, where NCAND = (2*RANGE+1)^2+1. Every later candidate ends at the hand-off.
- R7: For any input, `done` rises no later than NCAND*(BLK/2+1)+3 clock edges after the accepted `start`.
- R8: The cost path holds BLK*BLK*(2^PIX_W-1) exactly. An all-maximum block against an all-zero window reports that value at the clamped predicted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when not busy |
| pred_mv_x | input | MV_W | Predicted horizontal displacement, signed |
| pred_mv_y | input | MV_W | Predicted vertical displacement, signed |
| cur_blk | input | BLK*BLK*PIX_W | Current block pixels, held from start to done |
| win_pix | input | WIN*WIN*PIX_W | Reference window pixels, held from start to done |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid; held until next start |
| best_mv_x | output | MV_W | Best horizontal displacement, signed |
| best_mv_y | output | MV_W | Best vertical displacement, signed |
| best_sad | output | SAD_W | Cost of the best displacement |

## Verification
The bench accepts `start` on one edge and counts edges until `done` is seen high at a falling edge. It holds that count against the R6 bound when the predicted vector matches exactly, and against the R7 bound in all other runs. The vector and cost are read in the first falling edge with `done` high. They are then read again three cycles later to confirm that they hold. The expected results come from an exhaustive search computed in the bench, so a wrongly skipped candidate shows up as a wrong vector or cost.

// File: rtl/sme_pkg.sv
package sme_pkg;
    // Absolute difference of two unsigned pixel values.
    function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/sme_cand_gen.sv
// Maps a candidate index to window offsets: index 0 is the clamped
// prediction, the rest walk the search square in raster order.
module sme_cand_gen #(
    parameter int RANGE = 8,
    parameter int MV_W  = 5,
    parameter int OFS_W = 5,
    parameter int IDX_W = 9
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [MV_W-1:0]  pred_x,
    input  logic signed [MV_W-1:0]  pred_y,
    output logic [OFS_W-1:0]        ofs_x,
    output logic [OFS_W-1:0]        ofs_y
);
    localparam int NS = 2 * RANGE + 1;

    int px, py, k;

    always_comb begin
        px = int'(pred_x);
        py = int'(pred_y);
        if (px > RANGE)  px = RANGE;
        if (px < -RANGE) px = -RANGE;
        if (py > RANGE)  py = RANGE;
        if (py < -RANGE) py = -RANGE;
        k = int'(idx) - 1;
        if (idx == '0) begin
            ofs_x = OFS_W'(px + RANGE);
            ofs_y = OFS_W'(py + RANGE);
        end else begin
            ofs_x = OFS_W'(k % NS);
            ofs_y = OFS_W'(k / NS);
        end
    end

    // R3: the offsets never leave the search square
    always_comb begin
        a_r3_ofs_in_range: assert (int'(ofs_x) <= 2 * RANGE && int'(ofs_y) <= 2 * RANGE);
    end
endmodule

// File: rtl/sme_row_sad.sv
// SAD of one block row against the window at a given offset.
module sme_row_sad #(
    parameter int BLK   = 8,
    parameter int PIX_W = 8,
    parameter int WIN   = 24,
    parameter int OFS_W = 5,
    parameter int ROW_W = 3,
    parameter int SAD_W = 14
) (
    input  logic [BLK*BLK*PIX_W-1:0] cur_blk,
    input  logic [WIN*WIN*PIX_W-1:0] win_pix,
    input  logic [ROW_W-1:0]         row,
    input  logic [OFS_W-1:0]         ofs_x,
    input  logic [OFS_W-1:0]         ofs_y,
    output logic [SAD_W-1:0]         sad
);
    logic [SAD_W-1:0] acc_d;

    always_comb begin
        acc_d = '0;
        for (int c = 0; c < BLK; c++) begin
            acc_d = acc_d + SAD_W'(sme_pkg::abs_diff(
                32'(cur_blk[(int'(row) * BLK + c) * PIX_W +: PIX_W]),
                32'(win_pix[((int'(row) + int'(ofs_y)) * WIN + c + int'(ofs_x)) * PIX_W +: PIX_W])));
        end
    end

    assign sad = acc_d;

    // R1: only rows inside the block are ever addressed
    always_comb begin
        a_r1_row_in_block: assert (int'(row) < BLK);
    end
endmodule

// File: rtl/sme_even_sad.sv
// Wide stage: one row unit per even row, summed in a single cycle.
module sme_even_sad #(
    parameter int BLK   = 8,
    parameter int PIX_W = 8,
    parameter int WIN   = 24,
    parameter int OFS_W = 5,
    parameter int ROW_W = 3,
    parameter int SAD_W = 14
) (
    input  logic [BLK*BLK*PIX_W-1:0] cur_blk,
    input  logic [WIN*WIN*PIX_W-1:0] win_pix,
    input  logic [OFS_W-1:0]         ofs_x,
    input  logic [OFS_W-1:0]         ofs_y,
    output logic [SAD_W-1:0]         sad
);
    localparam int HALF = BLK / 2;

    logic [SAD_W-1:0] row_part [HALF];
    logic [SAD_W-1:0] sum_d;

    for (genvar g = 0; g < HALF; g++) begin : g_even_row
        sme_row_sad #(
            .BLK(BLK), .PIX_W(PIX_W), .WIN(WIN),
            .OFS_W(OFS_W), .ROW_W(ROW_W), .SAD_W(SAD_W)
        ) u_row (
            .cur_blk (cur_blk),
            .win_pix (win_pix),
            .row     (ROW_W'(2 * g)),
            .ofs_x   (ofs_x),
            .ofs_y   (ofs_y),
            .sad     (row_part[g])
        );
    end

    always_comb begin
        sum_d = '0;
        for (int g = 0; g < HALF; g++) begin
            sum_d = sum_d + row_part[g];
        end
    end

    assign sad = sum_d;
endmodule

// File: rtl/sad_motion_est.sv
module sad_motion_est #(
    parameter int BLK   = 8,
    parameter int PIX_W = 8,
    parameter int RANGE = 8,
    localparam int WIN     = BLK + 2 * RANGE,
    localparam int NS      = 2 * RANGE + 1,
    localparam int NCAND   = NS * NS + 1,
    localparam int IDX_W   = $clog2(NCAND),
    localparam int HALF    = BLK / 2,
    localparam int KW      = $clog2(HALF + 1),
    localparam int ROW_W   = (BLK > 1) ? $clog2(BLK) : 1,
    localparam int MAX_SAD = BLK * BLK * ((1 << PIX_W) - 1),
    localparam int SAD_W   = $clog2(MAX_SAD + 2),
    localparam int MV_W    = $clog2(RANGE + 1) + 1,
    localparam int OFS_W   = $clog2(NS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [MV_W-1:0]   pred_mv_x,
    input  logic signed [MV_W-1:0]   pred_mv_y,
    input  logic [BLK*BLK*PIX_W-1:0] cur_blk,
    input  logic [WIN*WIN*PIX_W-1:0] win_pix,
    output logic                     busy,
    output logic                     done,
    output logic signed [MV_W-1:0]   best_mv_x,
    output logic signed [MV_W-1:0]   best_mv_y,
    output logic [SAD_W-1:0]         best_sad
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             par_run;
        logic [IDX_W-1:0] par_idx;
        logic             slot_vld;
        logic [OFS_W-1:0] slot_ox;
        logic [OFS_W-1:0] slot_oy;
        logic [SAD_W-1:0] slot_part;
        logic             ser_vld;
        logic [OFS_W-1:0] ser_ox;
        logic [OFS_W-1:0] ser_oy;
        logic [KW-1:0]    ser_k;
        logic [SAD_W-1:0] ser_sum;
        logic [OFS_W-1:0] best_ox;
        logic [OFS_W-1:0] best_oy;
        logic [SAD_W-1:0] best_sad;
        logic [MV_W-1:0]  pred_x;
        logic [MV_W-1:0]  pred_y;
    } state_t;

    state_t q, d;

    logic [OFS_W-1:0] cg_ox, cg_oy;
    logic [SAD_W-1:0] even_sad, odd_row_sad, ser_new;
    logic             slot_take;

    sme_cand_gen #(
        .RANGE(RANGE), .MV_W(MV_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
    ) u_cand (
        .idx    (q.par_idx),
        .pred_x ($signed(q.pred_x)),
        .pred_y ($signed(q.pred_y)),
        .ofs_x  (cg_ox),
        .ofs_y  (cg_oy)
    );

    sme_even_sad #(
        .BLK(BLK), .PIX_W(PIX_W), .WIN(WIN),
        .OFS_W(OFS_W), .ROW_W(ROW_W), .SAD_W(SAD_W)
    ) u_even (
        .cur_blk (cur_blk),
        .win_pix (win_pix),
        .ofs_x   (cg_ox),
        .ofs_y   (cg_oy),
        .sad     (even_sad)
    );

    sme_row_sad #(
        .BLK(BLK), .PIX_W(PIX_W), .WIN(WIN),
        .OFS_W(OFS_W), .ROW_W(ROW_W), .SAD_W(SAD_W)
    ) u_odd (
        .cur_blk (cur_blk),
        .win_pix (win_pix),
        .row     (ROW_W'({q.ser_k, 1'b1})),
        .ofs_x   (q.ser_ox),
        .ofs_y   (q.ser_oy),
        .sad     (odd_row_sad)
    );

    always_comb begin
        d         = q;
        slot_take = q.slot_vld && !q.ser_vld;
        ser_new   = q.ser_sum + odd_row_sad;

        // Row-serial completion of the odd rows
        if (q.ser_vld) begin
            if (ser_new >= q.best_sad) begin
                d.ser_vld = 1'b0;
            end else if (q.ser_k == KW'(HALF - 1)) begin
                d.ser_vld  = 1'b0;
                d.best_sad = ser_new;
                d.best_ox  = q.ser_ox;
                d.best_oy  = q.ser_oy;
            end else begin
                d.ser_sum = ser_new;
                d.ser_k   = q.ser_k + KW'(1);
            end
        end else if (q.slot_vld) begin
            d.slot_vld = 1'b0;
            if (q.slot_part < q.best_sad) begin
                d.ser_vld = 1'b1;
                d.ser_sum = q.slot_part;
                d.ser_k   = '0;
                d.ser_ox  = q.slot_ox;
                d.ser_oy  = q.slot_oy;
            end
        end

        // Wide even-row stage fills the hand-off slot
        if (q.par_run && (!q.slot_vld || slot_take)) begin
            d.slot_vld  = 1'b1;
            d.slot_ox   = cg_ox;
            d.slot_oy   = cg_oy;
            d.slot_part = even_sad;
            if (q.par_idx == IDX_W'(NCAND - 1)) begin
                d.par_run = 1'b0;
            end else begin
                d.par_idx = q.par_idx + IDX_W'(1);
            end
        end

        if (q.busy && !q.par_run && !q.slot_vld && !q.ser_vld) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end

        if (start && !q.busy) begin
            d.busy     = 1'b1;
            d.done     = 1'b0;
            d.par_run  = 1'b1;
            d.par_idx  = '0;
            d.slot_vld = 1'b0;
            d.ser_vld  = 1'b0;
            d.best_sad = '1;
            d.pred_x   = pred_mv_x;
            d.pred_y   = pred_mv_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.best_sad <= '1;
            q.best_ox  <= OFS_W'(RANGE);
            q.best_oy  <= OFS_W'(RANGE);
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign best_sad  = q.best_sad;
    assign best_mv_x = MV_W'(int'(q.best_ox) - RANGE);
    assign best_mv_y = MV_W'(int'(q.best_oy) - RANGE);

    // R1: the stored minimum never rises during a search
    a_r1_min_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> (q.best_sad <= $past(q.best_sad)));

    // R2: a candidate in the serial pass is always still beating the minimum
    a_r2_serial_below_min: assert property (@(posedge clk) disable iff (!rst_n)
        q.ser_vld |-> (q.ser_sum < q.best_sad));

    // R4: result frozen while done and no new start
    a_r4_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !start) |=> (q.done && $stable(q.best_sad) && $stable(q.best_ox) && $stable(q.best_oy)));

    // R4: done and busy never overlap
    a_r4_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy);

    // R4: a start while busy restarts nothing
    a_r4_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && q.par_run) |=> (q.par_idx != '0));
endmodule

// File: tb/sad_motion_est_bench.sv
module sad_motion_est_bench;
    localparam int BLK   = 4;
    localparam int PIX   = 8;
    localparam int R     = 2;
    localparam int WIN   = BLK + 2 * R;
    localparam int NS    = 2 * R + 1;
    localparam int NC    = NS * NS + 1;
    localparam int HALF  = BLK / 2;
    localparam int MVW   = $clog2(R + 1) + 1;
    localparam int SADW  = $clog2(BLK * BLK * 255 + 2);
    localparam int FAST  = NC + HALF + 2;
    localparam int SLOW  = NC * (HALF + 1) + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [MVW-1:0] pred_x = '0, pred_y = '0;
    logic [BLK*BLK*PIX-1:0] cur = '0;
    logic [WIN*WIN*PIX-1:0] win = '0;
    logic busy, done;
    logic signed [MVW-1:0] bx, by;
    logic [SADW-1:0] bsad;

    int cur_a [BLK*BLK];
    int win_a [WIN*WIN];
    int n_cmp = 0;
    int n_bad = 0;
    int seed = 7;

    always #5 clk = ~clk;

    sad_motion_est #(.BLK(BLK), .PIX_W(PIX), .RANGE(R)) u_sad_motion_est (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pred_mv_x(pred_x), .pred_mv_y(pred_y),
        .cur_blk(cur), .win_pix(win),
        .busy(busy), .done(done),
        .best_mv_x(bx), .best_mv_y(by), .best_sad(bsad)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_le(input string req, input int act, input int lim);
        n_cmp++;
        if (act > lim) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    function automatic int clampv(input int v);
        if (v > R) return R;
        if (v < -R) return -R;
        return v;
    endfunction

    function automatic int ref_sad(input int dx, input int dy);
        int s = 0;
        for (int r = 0; r < BLK; r++) begin
            for (int c = 0; c < BLK; c++) begin
                int a = cur_a[r * BLK + c];
                int b = win_a[(r + dy + R) * WIN + c + dx + R];
                s += (a > b) ? a - b : b - a;
            end
        end
        return s;
    endfunction

    task automatic cur_from_win(input int dx, input int dy);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++)
                cur_a[r * BLK + c] = win_a[(r + dy + R) * WIN + c + dx + R];
    endtask

    task automatic run_case(input int pxi, input int pyi, input int bound,
                            input bit poke, input string mv_tag, input string t_tag);
        int cx, cy, ex, ey, es, s, cyc;
        int hx, hy, hs;
        for (int i = 0; i < BLK * BLK; i++) cur[i * PIX +: PIX] = PIX'(cur_a[i]);
        for (int i = 0; i < WIN * WIN; i++) win[i * PIX +: PIX] = PIX'(win_a[i]);
        cx = clampv(pxi);
        cy = clampv(pyi);
        es = ref_sad(cx, cy);
        ex = cx;
        ey = cy;
        for (int y = -R; y <= R; y++) begin
            for (int x = -R; x <= R; x++) begin
                s = ref_sad(x, y);
                if (s < es) begin es = s; ex = x; ey = y; end
            end
        end
        pred_x = MVW'(pxi);
        pred_y = MVW'(pyi);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = (poke && cyc == 3) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        chk("R7 watchdog", int'(done), 1);
        chk("R1 min sad", int'(bsad), es);
        chk({mv_tag, " mv x"}, int'(bx), ex);
        chk({mv_tag, " mv y"}, int'(by), ey);
        chk_le({t_tag, " done latency"}, cyc, bound);
        hx = int'(bx); hy = int'(by); hs = int'(bsad);
        repeat (3) @(negedge clk);
        chk("R4 done held", int'(done), 1);
        chk("R4 sad held", int'(bsad), hs);
        chk("R4 mv held", int'(bx) * 100 + int'(by), hx * 100 + hy);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL R7 global watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state
        chk("R5 busy", int'(busy), 0);
        chk("R5 done", int'(done), 0);
        chk("R5 sad", int'(bsad), (1 << SADW) - 1);
        chk("R5 mv", int'(bx) * 100 + int'(by), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: exact match at the predicted vector, every displacement
        for (int dy = -R; dy <= R; dy++) begin
            for (int dx = -R; dx <= R; dx++) begin
                for (int i = 0; i < WIN * WIN; i++) win_a[i] = rnd();
                cur_from_win(dx, dy);
                run_case(dx, dy, FAST, 1'b0, "R2", "R6");
            end
        end

        // R1/R7: exact match elsewhere, prediction at zero
        for (int dy = -R; dy <= R; dy++) begin
            for (int dx = -R; dx <= R; dx++) begin
                for (int i = 0; i < WIN * WIN; i++) win_a[i] = rnd();
                cur_from_win(dx, dy);
                run_case(0, 0, SLOW, 1'b0, "R1", "R7");
            end
        end

        // R1/R4: unrelated block and window, start poked while busy
        for (int n = 0; n < 12; n++) begin
            for (int i = 0; i < WIN * WIN; i++) win_a[i] = rnd();
            for (int i = 0; i < BLK * BLK; i++) cur_a[i] = rnd();
            run_case((n % NS) - R, ((n / 2) % NS) - R, SLOW, n[0], "R1", "R7");
        end

        // R2/R3: all costs equal, out-of-range predictions clamp
        for (int i = 0; i < WIN * WIN; i++) win_a[i] = 40;
        for (int i = 0; i < BLK * BLK; i++) cur_a[i] = 90;
        run_case(3, -4, SLOW, 1'b0, "R3", "R7");
        run_case(-4, 3, SLOW, 1'b0, "R3", "R7");
        run_case(1, -1, SLOW, 1'b0, "R2", "R7");

        // R2: periodic window, several exact matches, raster order decides
        for (int y = 0; y < WIN; y++)
            for (int x = 0; x < WIN; x++)
                win_a[y * WIN + x] = (x % 2) * 100 + (y % 2) * 30 + 5;
        cur_from_win(1, 1);
        run_case(2, -2, SLOW, 1'b0, "R2", "R7");
        run_case(-1, -1, SLOW, 1'b0, "R2", "R7");

        // R8: full-scale cost
        for (int i = 0; i < WIN * WIN; i++) win_a[i] = 0;
        for (int i = 0; i < BLK * BLK; i++) cur_a[i] = 255;
        run_case(3, 3, SLOW, 1'b0, "R8", "R7");
        chk("R8 full scale sad", int'(bsad), BLK * BLK * 255);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule